// File: doc/BRIEF.md
# Frame Video Signature Analyser

This block reduces the pixel stream of one displayed frame to a single 16-bit check word. A self-test routine plays a known image through the display path and compares the word against a stored golden value, so the whole frame is judged through one register read. The pixel bus is 8 bits wide and comes with an active-display qualifier and a frame-start strobe.

Software drives the block through a 4-bit control word and a 16-bit data port. The control word sets a run bit that releases the signature register from its preload, a start bit whose rising edge arms a capture, a zero-input bit that folds zeros in place of live pixels, and an access bit that makes the data port visible. A capture covers exactly one frame, from one frame-start strobe to the next. A done flag then goes high and stays high until software re-arms.

Top module: `vsig_top`

## Requirements
- R1: The control word is loaded from `ctl_wdata` when `ctl_wr` is high. Bit 0 is start, bit 1 is run, bit 2 is zero-input and bit 3 is data access. After reset all four bits are 0.
- R2: While run is 0, the signature register is loaded with 16'h0001 on every clock, any capture in progress is abandoned and done is cleared.
- R3: Each folded step computes next = ((sig << 1) XOR (sig[15] ? 16'h1021 : 0)) XOR {8'h00, pixel}. This is a multiple-input shift register with polynomial x^16+x^12+x^5+1.
- R4: A capture is armed only by a 0-to-1 change of the start bit while run is 1. Setting start while run is 0 and then setting run arms nothing. Once armed, the capture window opens at the next `frm_strobe` and closes at the following one. Pixels seen before the opening strobe are ignored, and strobe cycles are never folded.
- R5: Inside the window, only cycles with `pix_act` high are folded. Blanking cycles leave the signature unchanged.
- R6: Each arming captures one frame only. After the closing strobe, later frames leave the signature unchanged until start is cleared and set again. Re-arming continues from the current signature and does not reload the preload value.
- R7: With zero-input set, each qualified pixel still causes one step, but the value folded in is 8'h00.
- R8: `data_rdata` shows the signature while access is 1 and reads 0 otherwise. `data_wr` loads `data_wdata` into the signature only while access is 1; otherwise the write is ignored.
- R9: `done` is 0 after reset. It rises in the cycle after the closing strobe and stays high until the next arming or until run goes to 0. Clearing start alone does not drop it.
- R10: Clearing start while armed or capturing returns the block to idle without raising `done`. The signature keeps the value it had reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word: start, run, zero-input, access (bits 0..3) |
| data_wr | input | 1 | Signature write strobe |
| data_wdata | input | 16 | Value loaded into the signature |
| data_rdata | output | 16 | Signature when access is set, else 0 |
| pix | input | 8 | Pixel data |
| pix_act | input | 1 | Active-display qualifier for `pix` |
| frm_strobe | input | 1 | One-cycle frame-start strobe |
| done | output | 1 | Captured frame complete |

## Verification
The bench builds the block with its default values: a 16-bit signature, an 8-bit pixel bus, preload 16'h0001 and feedback mask 16'h1021. With these values an independent reference step can be computed in the bench and compared word for word. Frames of only a few short lines, with blanking gaps and pixels before the opening strobe, are enough to reach every transition of the capture sequence. These include the second-frame freeze, re-arming without a reload, an abort in mid-frame and an arming attempt while run is low.

// File: rtl/vsig_pkg.sv
package vsig_pkg;

    localparam int CTL_W = 4;

    // control word, bit 0 = start ... bit 3 = access
    typedef struct packed {
        logic access;
        logic zero;
        logic run;
        logic start;
    } ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAPT  = 2'd2,
        ST_DONE  = 2'd3
    } st_e;

endpackage

// File: rtl/vsig_ctl.sv
module vsig_ctl
    import vsig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl_q,
    output logic             arm
);

    logic start_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '0;
            start_d <= 1'b0;
        end else begin
            if (wr)
                ctl_q <= ctl_t'(wdata);
            start_d <= ctl_q.start;
        end
    end

    // edge of start counts only while the register is released
    assign arm = ctl_q.start & ~start_d & ctl_q.run;

endmodule

// File: rtl/vsig_seq.sv
module vsig_seq
    import vsig_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic start,
    input  logic arm,
    input  logic strobe,
    input  logic pix_act,
    output st_e  st,
    output logic fold,
    output logic done
);

    st_e st_nx;

    always_comb begin
        st_nx = st;
        if (!run) begin
            st_nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:  if (arm) st_nx = ST_ARMED;
                ST_ARMED: if (!start) st_nx = ST_IDLE;
                          else if (strobe) st_nx = ST_CAPT;
                ST_CAPT:  if (!start) st_nx = ST_IDLE;
                          else if (strobe) st_nx = ST_DONE;
                ST_DONE:  if (arm) st_nx = ST_ARMED;
                default:  st_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    assign fold = (st == ST_CAPT) && start && run && pix_act && !strobe;
    assign done = (st == ST_DONE);

endmodule

// File: rtl/vsig_misr.sv
module vsig_misr #(
    parameter int               SIG_W = 16,
    parameter int               PIX_W = 8,
    parameter logic [SIG_W-1:0] POLY  = 16'h1021,
    parameter logic [SIG_W-1:0] SEED  = 16'h0001
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_seed,
    input  logic             ld,
    input  logic [SIG_W-1:0] ld_val,
    input  logic             fold,
    input  logic             zero,
    input  logic [PIX_W-1:0] pix,
    output logic [SIG_W-1:0] sig
);

    localparam int PAD_W = SIG_W - PIX_W;

    logic [PIX_W-1:0] din;
    logic [SIG_W-1:0] shifted;
    logic [SIG_W-1:0] stepped;

    assign din     = zero ? '0 : pix;
    assign shifted = {sig[SIG_W-2:0], 1'b0} ^ (sig[SIG_W-1] ? POLY : '0);

    generate
        if (PAD_W > 0) begin : g_pad
            assign stepped = shifted ^ {{PAD_W{1'b0}}, din};
        end else begin : g_full
            assign stepped = shifted ^ din[SIG_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || hold_seed) sig <= SEED;
        else if (ld)          sig <= ld_val;
        else if (fold)        sig <= stepped;
    end

endmodule

// File: rtl/vsig_top.sv
module vsig_top
    import vsig_pkg::*;
#(
    parameter int               SIG_W = 16,
    parameter int               PIX_W = 8,
    parameter logic [SIG_W-1:0] POLY  = 16'h1021,
    parameter logic [SIG_W-1:0] SEED  = 16'h0001
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [3:0]       ctl_wdata,
    input  logic             data_wr,
    input  logic [SIG_W-1:0] data_wdata,
    output logic [SIG_W-1:0] data_rdata,
    input  logic [PIX_W-1:0] pix,
    input  logic             pix_act,
    input  logic             frm_strobe,
    output logic             done
);

    ctl_t             ctl_q;
    logic             arm;
    st_e              st;
    logic             fold;
    logic [SIG_W-1:0] sig;

    vsig_ctl u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl_wr),
        .wdata (ctl_wdata),
        .ctl_q (ctl_q),
        .arm   (arm)
    );

    vsig_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .run     (ctl_q.run),
        .start   (ctl_q.start),
        .arm     (arm),
        .strobe  (frm_strobe),
        .pix_act (pix_act),
        .st      (st),
        .fold    (fold),
        .done    (done)
    );

    vsig_misr #(
        .SIG_W (SIG_W),
        .PIX_W (PIX_W),
        .POLY  (POLY),
        .SEED  (SEED)
    ) u_misr (
        .clk       (clk),
        .rst       (rst),
        .hold_seed (~ctl_q.run),
        .ld        (data_wr & ctl_q.access),
        .ld_val    (data_wdata),
        .fold      (fold),
        .zero      (ctl_q.zero),
        .pix       (pix),
        .sig       (sig)
    );

    assign data_rdata = ctl_q.access ? sig : '0;

endmodule

// File: rtl/vsig_chk.sv
module vsig_chk
    import vsig_pkg::*;
#(
    parameter int               SIG_W = 16,
    parameter logic [SIG_W-1:0] SEED  = 16'h0001
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             access,
    input logic             data_wr,
    input logic             pix_act,
    input logic             frm_strobe,
    input logic             done,
    input st_e              st,
    input logic [SIG_W-1:0] sig
);

    // R2
    seed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (sig == SEED));

    // R2
    done_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !done);

    // R9
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(frm_strobe));

    // R5
    blank_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !pix_act && !(data_wr && access)) |=> $stable(sig));

    // R6
    one_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (run && st == ST_DONE && !(data_wr && access)) |=> $stable(sig));

    // R8
    write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (run && data_wr && !access && st != ST_CAPT) |=> $stable(sig));

endmodule

bind vsig_top vsig_chk #(
    .SIG_W (SIG_W),
    .SEED  (SEED)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (ctl_q.run),
    .access     (ctl_q.access),
    .data_wr    (data_wr),
    .pix_act    (pix_act),
    .frm_strobe (frm_strobe),
    .done       (done),
    .st         (st),
    .sig        (sig)
);

// File: tb/sim_vsig_top.sv
module sim_vsig_top;

    localparam logic [15:0] POLY = 16'h1021;
    localparam logic [15:0] SEED = 16'h0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [3:0]  ctl_wdata = '0;
    logic        data_wr = 1'b0;
    logic [15:0] data_wdata = '0;
    logic [15:0] data_rdata;
    logic [7:0]  pix = '0;
    logic        pix_act = 1'b0;
    logic        frm_strobe = 1'b0;
    logic        done;

    always #2.5 clk = ~clk;

    vsig_top #(.SIG_W(16), .PIX_W(8), .POLY(POLY), .SEED(SEED)) u0 (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .data_wr(data_wr), .data_wdata(data_wdata), .data_rdata(data_rdata),
        .pix(pix), .pix_act(pix_act), .frm_strobe(frm_strobe), .done(done)
    );

    int          n_vec = 0;
    int          n_bad = 0;
    logic [15:0] exp_q[$];
    logic [15:0] model;
    bit          finished = 1'b0;

    function automatic logic [15:0] ref_step(logic [15:0] s, logic [7:0] d);
        return {s[14:0], 1'b0} ^ (s[15] ? POLY : 16'h0000) ^ {8'h00, d};
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    // R1: bit0 start, bit1 run, bit2 zero, bit3 access
    task automatic wr_ctl(logic [3:0] v);
        ctl_wr = 1'b1; ctl_wdata = v; tick();
        ctl_wr = 1'b0; tick(2);
    endtask

    task automatic wr_data(logic [15:0] v);
        data_wr = 1'b1; data_wdata = v; tick();
        data_wr = 1'b0; tick();
    endtask

    // driver: plays a frame, folds the expected signature, queues it
    task automatic frame(int lines, int act, int blank, bit zero, bit expect_done);
        repeat (3) begin pix_act = 1'b1; pix = 8'($urandom); tick(); end
        pix_act = 1'b0; frm_strobe = 1'b1; tick(); frm_strobe = 1'b0;
        for (int l = 0; l < lines; l++) begin
            for (int a = 0; a < act; a++) begin
                pix_act = 1'b1; pix = 8'($urandom);
                if (expect_done) model = ref_step(model, zero ? 8'h00 : pix);
                tick();
            end
            for (int b = 0; b < blank; b++) begin
                pix_act = 1'b0; pix = 8'($urandom); tick();
            end
        end
        pix_act = 1'b1; pix = 8'hA5; frm_strobe = 1'b1;
        if (expect_done) exp_q.push_back(model);
        tick();
        frm_strobe = 1'b0; pix_act = 1'b0; pix = '0;
        tick(2);
    endtask

    // monitor: compares the readback at each rise of done
    initial begin
        logic pd = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (done && !pd) begin
                    if (exp_q.size() == 0) begin
                        n_vec++; n_bad++;
                        $display("FAIL R9 unexpected done actual=1 expected=0");
                    end else begin
                        check("R3 R4 R5 frame signature", data_rdata, exp_q.pop_front());
                    end
                end
                pd = done;
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        check("R9 done after reset", done, 0);
        check("R8 hidden after reset", data_rdata, 0);

        wr_ctl(4'b1000);
        check("R2 preload while run low", data_rdata, SEED);

        wr_ctl(4'b0010);
        wr_data(16'hBEEF);
        check("R8 hidden without access", data_rdata, 0);
        wr_ctl(4'b1010);
        check("R8 write ignored without access", data_rdata, SEED);
        wr_data(16'h1234);
        check("R8 write with access", data_rdata, 16'h1234);
        wr_ctl(4'b1000);
        check("R2 run low reloads preload", data_rdata, SEED);

        // random frame
        model = SEED;
        wr_ctl(4'b1010);
        wr_ctl(4'b1011);
        check("R4 no done while armed", done, 0);
        frame(4, 12, 5, 1'b0, 1'b1);
        check("R9 done after frame", done, 1);

        // second frame with start still set
        frame(2, 8, 3, 1'b0, 1'b0);
        check("R6 frozen after one frame", data_rdata, model);
        check("R6 done held", done, 1);

        // clear, then re-arm without reload
        wr_ctl(4'b1010);
        check("R9 done kept when start cleared", done, 1);
        wr_ctl(4'b1011);
        check("R9 done dropped on re-arm", done, 0);
        frame(3, 10, 4, 1'b0, 1'b1);
        check("R6 continued signature", data_rdata, model);

        // zero-input reference frame
        wr_ctl(4'b1000);
        check("R2 done cleared by run low", done, 0);
        model = SEED;
        wr_ctl(4'b1110);
        wr_ctl(4'b1111);
        frame(3, 9, 2, 1'b1, 1'b1);
        check("R7 zero-input signature", data_rdata, model);

        // abort in mid-frame
        wr_ctl(4'b1010);
        wr_ctl(4'b1011);
        frm_strobe = 1'b1; tick(); frm_strobe = 1'b0;
        for (int i = 0; i < 5; i++) begin
            pix_act = 1'b1; pix = 8'($urandom);
            model = ref_step(model, pix);
            tick();
        end
        pix_act = 1'b0;
        wr_ctl(4'b1010);
        frm_strobe = 1'b1; tick(); frm_strobe = 1'b0; tick(2);
        check("R10 no done after abort", done, 0);
        check("R10 partial value kept", data_rdata, model);

        // start set while run low does not arm
        wr_ctl(4'b1000);
        wr_ctl(4'b1001);
        wr_ctl(4'b1011);
        frame(2, 6, 2, 1'b0, 1'b0);
        check("R4 no arming without edge under run", done, 0);
        check("R4 signature untouched", data_rdata, SEED);

        tick(2);
        check("R9 no pending frames", 16'(exp_q.size()), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule